// File: doc/BRIEF.md
# Doubleword DRAM Module Controller with Open-Row Reuse

This controller connects a CPU-side request port to a memory module built from eight byte-wide DRAM chips. The chips work in parallel and together hold one 64-bit doubleword per location. The CPU supplies a word address, a read/write flag and, for writes, a doubleword.

The controller splits the word address into a row and a column. It sends both values to all chips at once on one shared set of address pins: first the row with a row strobe, then the column with a column strobe. Each chip carries one byte lane of the doubleword. On a read the controller assembles the lanes into one word, and on a write it spreads the word across the lanes.

After an access, the row stays open in every chip. A later access to the same row then needs only a column strobe. An access to a different row first closes the open row, then opens the new one. A refresh request waits until no transfer is running. The controller closes any open row before it issues the refresh strobe.

Top module: `dword_dram_ctrl`

## Requirements
- R1: The word address is `{row, column}`, with the row in the upper ROW_W bits and the column in the lower COL_W bits. The row value appears on `mem_addr` during the cycle of `mem_row_stb`, and the column value appears on `mem_addr` during the cycle of `mem_col_stb`.
- R2: Byte lane k of the doubleword (bits 8k+7 down to 8k) is carried by chip k in both directions, for k from 0 to 7.
- R3: An access that finds no row open issues exactly one `mem_row_stb`, and `mem_col_stb` follows in the very next cycle, with no `mem_pre`.
- R4: An access whose row equals the open row issues only `mem_col_stb`, with no `mem_row_stb` and no `mem_pre`. The column strobe comes in the cycle after the request is seen in idle.
- R5: An access to a row other than the open one issues `mem_pre`, then `mem_row_stb`, then `mem_col_stb`, each exactly once.
- R6: During the column strobe of a write, `mem_we` is 1 and `mem_dq_out` equals `req_wdata`. A later read of that address returns the written word. During the column strobe of a read, `mem_we` is 0.
- R7: On a read, `rsp_rdata` holds the word the chips returned in the cycle after the column strobe. It is valid in the cycle in which `req_ready` is high, two cycles after the column strobe.
- R8: The request stays asserted and stable until completion. `req_ready` is high for exactly one cycle per transaction, at completion, for reads and writes alike.
- R9: A pulse on `refresh_req` is served only while no transfer is in progress. A refresh that is pending in idle is served before a waiting request. If a row is open, `mem_pre` precedes `mem_ref`. The next access after a refresh opens its row without a `mem_pre`.
- R10: After reset, no strobe is active, `req_ready` is 0 and no row counts as open, so the first access follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address `{row, column}` |
| req_wdata | input | 64 | Write doubleword |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read doubleword, valid with `req_ready` |
| refresh_req | input | 1 | Refresh request pulse |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address pins to all chips |
| mem_row_stb | output | 1 | Open-row strobe |
| mem_col_stb | output | 1 | Column strobe |
| mem_pre | output | 1 | Close-row strobe |
| mem_ref | output | 1 | Refresh strobe |
| mem_we | output | 1 | Write select during the column strobe |
| mem_dq_out | output | 64 | Write data, byte lane k to chip k |
| mem_dq_in | input | 64 | Read data, byte lane k from chip k, one cycle after the column strobe |

## Verification
The stored open row is the state most likely to go wrong. If it is stale or wrong, the next access shows a missing or extra row or close strobe at once. The bench's chip model then sees a column strobe to a closed row, or a row strobe on top of an open one, in that same transaction. A swapped byte lane or a wrong address field shows up as a wrong doubleword on the first read-back, or as a wrong value on `mem_addr` during the strobe cycle itself. A lost refresh is reported when the refresh strobe fails to appear before the next transaction starts its row access. A refresh issued mid-transfer is reported in the cycle it fires.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACT  = 3'd2,
    ST_COL  = 3'd3,
    ST_CAPT = 3'd4,
    ST_DONE = 3'd5,
    ST_REF  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/dctl_addr_split.sv
module dctl_addr_split #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic [ROW_W+COL_W-1:0] word_addr,
  input  logic                   row_phase,
  output logic [ROW_W-1:0]       row_f,
  output logic [COL_W-1:0]       col_f,
  output logic [PIN_W-1:0]       pin_addr
);
  assign row_f = word_addr[ROW_W+COL_W-1:COL_W];
  assign col_f = word_addr[COL_W-1:0];

  always_comb begin
    if (row_phase) pin_addr = PIN_W'(row_f);
    else           pin_addr = PIN_W'(col_f);
  end
endmodule

// File: rtl/dctl_row_track.sv
module dctl_row_track #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row_in,
  input  logic             open_en,
  input  logic             close_en,
  output logic             row_hit,
  output logic             row_open
);
  logic [ROW_W-1:0] open_row_q, open_row_d;
  logic             open_q, open_d;

  always_comb begin
    open_row_d = open_row_q;
    open_d     = open_q;
    if (close_en) open_d = 1'b0;
    if (open_en) begin
      open_d     = 1'b1;
      open_row_d = row_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else begin
      open_q     <= open_d;
      open_row_q <= open_row_d;
    end
  end

  assign row_open = open_q;
  assign row_hit  = open_q && (open_row_q == row_in);

  // R3
  open_sets_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |=> (row_open && row_hit));
  // R5
  close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_en && !open_en) |=> !row_open);
endmodule

// File: rtl/dctl_lane_map.sv
module dctl_lane_map #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_lanes,
  input  logic [DATA_W-1:0] rd_lanes,
  output logic [DATA_W-1:0] rd_word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] cap_q, cap_d;

    assign wr_lanes[k*LANE_W +: LANE_W] = wr_word[k*LANE_W +: LANE_W];

    always_comb begin
      cap_d = cap_q;
      if (cap_en) cap_d = rd_lanes[k*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= '0;
      else        cap_q <= cap_d;
    end

    assign rd_word[k*LANE_W +: LANE_W] = cap_q;
  end

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rd_word));
endmodule

// File: rtl/dctl_seq.sv
module dctl_seq
  import dctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic row_hit,
  input  logic row_open,
  input  logic refresh_req,
  output logic row_stb,
  output logic col_stb,
  output logic pre_stb,
  output logic ref_stb,
  output logic we,
  output logic cap_en,
  output logic req_ready,
  output logic row_phase
);
  seq_state_t state_q, state_d;
  logic       pend_q, pend_d;
  logic       svc_q, svc_d;

  always_comb begin
    state_d = state_q;
    svc_d   = svc_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          svc_d   = 1'b1;
          state_d = row_open ? ST_PRE : ST_REF;
        end else if (req_valid) begin
          if (row_hit)       state_d = ST_COL;
          else if (row_open) state_d = ST_PRE;
          else               state_d = ST_ACT;
        end
      end
      ST_PRE:  state_d = svc_q ? ST_REF : ST_ACT;
      ST_ACT:  state_d = ST_COL;
      ST_COL:  state_d = ST_CAPT;
      ST_CAPT: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_REF: begin
        state_d = ST_IDLE;
        svc_d   = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (state_q == ST_REF) pend_d = 1'b0;
    if (refresh_req)       pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      svc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      svc_q   <= svc_d;
    end
  end

  assign row_stb   = (state_q == ST_ACT);
  assign col_stb   = (state_q == ST_COL);
  assign pre_stb   = (state_q == ST_PRE);
  assign ref_stb   = (state_q == ST_REF);
  assign cap_en    = (state_q == ST_CAPT) && !req_write;
  assign req_ready = (state_q == ST_DONE);
  assign we        = col_stb && req_write;
  assign row_phase = (state_q == ST_ACT);

  // R3
  act_then_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> col_stb);
  // R4
  hit_no_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !pend_q && req_valid && row_hit) |=> col_stb);
  // R7
  ready_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> $past(col_stb, 2));
  // R8
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R9
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |-> !row_open);
  // R10
  col_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |-> row_open);
endmodule

// File: rtl/dword_dram_ctrl.sv
module dword_dram_ctrl #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int DATA_W = LANES * LANE_W,
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              refresh_req,
  output logic [PIN_W-1:0]  mem_addr,
  output logic              mem_row_stb,
  output logic              mem_col_stb,
  output logic              mem_pre,
  output logic              mem_ref,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic [ROW_W-1:0] row_f;
  logic [COL_W-1:0] col_f;
  logic             row_phase, row_hit, row_open, cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  dctl_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_split (
    .word_addr (req_addr),
    .row_phase (row_phase),
    .row_f     (row_f),
    .col_f     (col_f),
    .pin_addr  (mem_addr)
  );

  dctl_row_track #(.ROW_W(ROW_W)) u_track (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .row_in   (row_f),
    .open_en  (mem_row_stb),
    .close_en (mem_pre),
    .row_hit  (row_hit),
    .row_open (row_open)
  );

  dctl_seq u_seq (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .row_hit     (row_hit),
    .row_open    (row_open),
    .refresh_req (refresh_req),
    .row_stb     (mem_row_stb),
    .col_stb     (mem_col_stb),
    .pre_stb     (mem_pre),
    .ref_stb     (mem_ref),
    .we          (mem_we),
    .cap_en      (cap_en),
    .req_ready   (req_ready),
    .row_phase   (row_phase)
  );

  dctl_lane_map #(.LANES(LANES), .LANE_W(LANE_W), .DATA_W(DATA_W)) u_lanes (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cap_en   (cap_en),
    .wr_word  (req_wdata),
    .wr_lanes (mem_dq_out),
    .rd_lanes (mem_dq_in),
    .rd_word  (rsp_rdata)
  );

  // R1
  col_addr_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_col_stb |-> (mem_addr == PIN_W'(req_addr[COL_W-1:0])));
endmodule

// File: tb/dword_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module dword_dram_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, mem_row_stb, mem_col_stb, mem_pre, mem_ref, mem_we;
  logic [63:0] rsp_rdata, mem_dq_out;
  logic [63:0] mem_dq_in = '0;
  logic [3:0]  mem_addr;

  always #4 clk = ~clk;

  dword_dram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .refresh_req(refresh_req), .mem_addr(mem_addr),
    .mem_row_stb(mem_row_stb), .mem_col_stb(mem_col_stb), .mem_pre(mem_pre),
    .mem_ref(mem_ref), .mem_we(mem_we), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(int k, int r, int c);
    return 8'(k * 37 + r * 16 + c);
  endfunction

  // eight byte-wide chip model, one cycle read latency
  logic [7:0] chip_mem [int];
  bit         m_open = 1'b0;
  logic [3:0] m_row = '0;

  always @(posedge clk) begin
    if (mem_pre) m_open <= 1'b0;
    if (mem_ref && m_open) chk(1'b0, "R9 ref with open row", 1, 0);
    if (mem_row_stb) begin
      if (m_open) chk(1'b0, "R5 open on open row", 1, 0);
      m_open <= 1'b1;
      m_row  <= mem_addr;
    end
    if (mem_col_stb) begin
      if (!m_open) chk(1'b0, "R3 column to closed row", 0, 1);
      for (int k = 0; k < 8; k++) begin
        int key;
        key = k * 256 + int'(m_row) * 16 + int'(mem_addr);
        if (mem_we) chip_mem[key] = mem_dq_out[k*8 +: 8];
        else mem_dq_in[k*8 +: 8] <= chip_mem.exists(key) ? chip_mem[key]
                                    : init_byte(k, int'(m_row), int'(mem_addr));
      end
    end
  end

  typedef struct {
    bit          wr;
    logic [63:0] data;
    logic [3:0]  row, col;
    int          acts, pres;
    bit          refb;
    string       req;
  } item_t;

  item_t       q[$];
  logic [63:0] shadow [int];
  int          cur_act = 0, cur_pre = 0, cur_col = 0, idle_pre = 0, idle_ref = 0;
  bit          cur_ref = 1'b0, prev_ready = 1'b0;

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_ref) begin
        if (q.size() == 0) idle_ref++;
        else begin
          chk(cur_act + cur_col == 0, "R9 refresh inside transfer", 1, 0);
          cur_ref = 1'b1;
        end
      end
      if (mem_pre) begin
        if (q.size() == 0) idle_pre++; else cur_pre++;
      end
      if (mem_row_stb && q.size() != 0) begin
        cur_act++;
        chk(mem_addr == q[0].row, "R1 row on pins", 64'(mem_addr), 64'(q[0].row));
      end
      if (mem_col_stb && q.size() != 0) begin
        cur_col++;
        chk(mem_addr == q[0].col, "R1 column on pins", 64'(mem_addr), 64'(q[0].col));
        chk(mem_we == q[0].wr, "R6 write select", 64'(mem_we), 64'(q[0].wr));
        if (q[0].wr) chk(mem_dq_out == q[0].data, "R6 write lanes", mem_dq_out, q[0].data);
      end
      if (req_ready) begin
        if (prev_ready) chk(1'b0, "R8 ready longer than one cycle", 1, 0);
        if (q.size() == 0) chk(1'b0, "R8 unexpected ready", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          if (!it.wr) chk(rsp_rdata == it.data, {it.req, " read data"}, rsp_rdata, it.data);
          chk(cur_act == it.acts, {it.req, " row strobes"}, 64'(cur_act), 64'(it.acts));
          chk(cur_pre == it.pres, {it.req, " close strobes"}, 64'(cur_pre), 64'(it.pres));
          chk(cur_ref == it.refb, {it.req, " refresh seen"}, 64'(cur_ref), 64'(it.refb));
          cur_act = 0; cur_pre = 0; cur_col = 0; cur_ref = 1'b0;
        end
      end
      prev_ready = req_ready;
    end
  end

  // driver
  task automatic access(input bit wr, input logic [7:0] a, input logic [63:0] wd,
                        input int acts, input int pres, input bit refb, input string req);
    item_t it;
    int    key;
    key = int'(a);
    it.wr = wr; it.row = a[7:4]; it.col = a[3:0];
    it.acts = acts; it.pres = pres; it.refb = refb; it.req = req;
    if (wr) begin
      it.data = wd;
      shadow[key] = wd;
    end else if (shadow.exists(key)) it.data = shadow[key];
    else for (int k = 0; k < 8; k++) it.data[k*8 +: 8] = init_byte(k, int'(a[7:4]), int'(a[3:0]));
    @(negedge clk);
    refresh_req = 1'b0;
    q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int p0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b0, "R10 ready after reset", 64'(req_ready), 0);
    chk({mem_row_stb, mem_col_stb, mem_pre, mem_ref} == 4'b0, "R10 strobes after reset",
        64'({mem_row_stb, mem_col_stb, mem_pre, mem_ref}), 0);
    access(1'b0, 8'h23, '0, 1, 0, 1'b0, "R10 R3 R7 first read");
    access(1'b0, 8'h25, '0, 0, 0, 1'b0, "R4 hit read");
    access(1'b1, 8'h27, 64'h0123_4567_89AB_CDEF, 0, 0, 1'b0, "R4 R6 hit write");
    access(1'b0, 8'h27, '0, 0, 0, 1'b0, "R6 read back");
    access(1'b1, 8'h51, 64'hA5A5_0F0F_F00F_5A5A, 1, 1, 1'b0, "R5 miss write");
    // R2 each chip holds its own byte lane
    for (int k = 0; k < 8; k++) begin
      int key;
      key = k * 256 + 5 * 16 + 1;
      chk(chip_mem.exists(key) && chip_mem[key] == 8'(64'hA5A5_0F0F_F00F_5A5A >> (8 * k)),
          "R2 lane to chip", 64'(chip_mem.exists(key) ? chip_mem[key] : 8'h00),
          64'(8'(64'hA5A5_0F0F_F00F_5A5A >> (8 * k))));
    end
    access(1'b0, 8'h27, '0, 1, 1, 1'b0, "R5 R2 miss read back");
    access(1'b0, 8'h51, '0, 1, 1, 1'b0, "R2 R7 lanes read");
    // R9 idle refresh with open row
    p0 = idle_pre; r0 = idle_ref;
    @(negedge clk); refresh_req = 1'b1;
    @(negedge clk); refresh_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(idle_ref == r0 + 1, "R9 idle refresh strobe", 64'(idle_ref), 64'(r0 + 1));
    chk(idle_pre == p0 + 1, "R9 close before refresh", 64'(idle_pre), 64'(p0 + 1));
    access(1'b0, 8'h51, '0, 1, 0, 1'b0, "R9 reopen after refresh");
    // R9 refresh raised mid-transfer waits, then beats the next request
    fork
      access(1'b1, 8'h53, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, 1'b0, "R9 transfer during refresh request");
      begin
        repeat (2) @(negedge clk);
        refresh_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
      end
    join
    access(1'b0, 8'h53, '0, 1, 1, 1'b1, "R9 deferred refresh first");
    access(1'b0, 8'hF0, '0, 1, 1, 1'b0, "R1 R5 top row");
    access(1'b1, 8'hF0, '1, 0, 0, 1'b0, "R8 R6 all ones write");
    access(1'b0, 8'hF0, '0, 0, 0, 1'b0, "R8 R7 all ones read");
    access(1'b0, 8'h0F, '0, 1, 1, 1'b0, "R1 R5 bottom row");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8 all transfers completed", 64'(q.size()), 0);
    finish_run();
  end
endmodule